// File: doc/BRIEF.md
# GPIO Pin Register Block

This block controls 32 general-purpose pins through a small 32-bit register bus. Software programs a direction word that marks each pin as output (1) or input (0). It reads back a pin-level word and keeps one spare 32-bit scratch word. Output pins are raised or lowered through dedicated set and clear offsets. A set or clear write is accepted only if its mask touches at least one pin that is currently an output. If the mask touches none, the write is dropped as a whole and a one-cycle error strobe is raised. Input pins are sampled into the level word every cycle through one register stage.

The bus has no stall and no back-pressure. Every access completes in the cycle where `we` or `re` is high, and the bus does not need to wait on anything. Read data is combinational on `rdata` while `re` is high. Writes take effect at the next rising clock edge. Only full 32-bit accesses exist. The three edge-related offsets (0x10, 0x14, 0x18) are decoded and then discarded. There is no edge detection, so the eight per-pin interrupt lines and the shared upper-pin line all stay low.

Top module: `gpio_regblock`

## Requirements
- R1: After reset, the level word, direction word and scratch word read as zero, `pin_oe` is zero and `wr_err` is low.
- R2: With `re` high, offset 0x00 returns the level word, offset 0x04 returns the direction word and offset 0x20 returns the scratch word, in the same cycle.
- R3: With `re` high, every other offset returns zero, including 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R4: A write to 0x04 loads the direction word, and a write to 0x20 loads the scratch word. Each is visible from the next cycle.
- R5: A write to 0x08 whose value ANDed with the current direction word is nonzero ORs the value into the output bits of the level word.
- R6: A write to 0x0C whose value overlaps the current direction word clears the written bits among the output bits of the level word.
- R7: A set or clear write whose value has no bit in common with the direction word changes nothing. `wr_err` is then high for exactly the following cycle. `wr_err` is low in every other cycle.
- R8: Writes to 0x10, 0x14, 0x18 and to any undecoded offset change no register.
- R9: For every bit whose direction is 0, the level word holds the value `pin_i` had in the previous cycle, whatever is written to set or clear.
- R10: `pin_o` equals level AND direction, and `pin_oe` equals the direction word.
- R11: `irq_low[7:0]` and `irq_high` stay low at all times.
- R12: While `re` is low, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational |
| pin_i | input | 32 | External pin values |
| pin_o | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq_low | output | 8 | Per-pin interrupt lines for pins 0 to 7 |
| irq_high | output | 1 | Shared interrupt line for the upper pins |
| wr_err | output | 1 | One-cycle strobe for a dropped set or clear write |

## Verification
The assertions run on every cycle. They check that a direction write lands, that accepted set and clear writes reach the output bits of the level word, and that input bits follow the pins one cycle late. They also check that a dropped write leaves the output bits untouched and that the error strobe only follows a set or clear write. The read decode cannot be checked that way: the return value of every offset, the zero returned by unknown and edge offsets, and the silent loss of writes to those offsets are shown only by the bench's directed and random accesses, each compared against its reference model. The same holds for the reset state and the quiet interrupt lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SET   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RISE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FALL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EDGE  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_AUX   = 8'h20;

  typedef struct packed {
    logic dir;
    logic aux;
    logic set;
    logic clr;
  } wr_strb_t;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_strb_t          strb
);
  always_comb begin
    strb = '0;
    if (we) begin
      unique case (addr)
        OFF_DIR: strb.dir = 1'b1;
        OFF_AUX: strb.aux = 1'b1;
        OFF_SET: strb.set = 1'b1;
        OFF_CLR: strb.clr = 1'b1;
        // edge offsets are accepted and dropped on purpose (R8)
        OFF_RISE, OFF_FALL, OFF_EDGE: strb = '0;
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_state.sv
module gpio_state
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strb_t          strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] level_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] aux_q,
  output logic              reject_q
);
  logic              hits_out;
  logic              accept;
  logic              reject;
  logic [DATA_W-1:0] modified;
  logic [DATA_W-1:0] level_d;

  assign hits_out = |(wdata & dir_q);
  assign accept   = (strb.set | strb.clr) & hits_out;
  assign reject   = (strb.set | strb.clr) & ~hits_out;

  always_comb begin
    modified = level_q;
    if (accept && strb.set) modified = level_q | wdata;
    if (accept && strb.clr) modified = level_q & ~wdata;
    // input bits follow the pins, output bits keep the register value
    level_d = (modified & dir_q) | (pin_i & ~dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      dir_q    <= '0;
      aux_q    <= '0;
      reject_q <= 1'b0;
    end else begin
      level_q  <= level_d;
      reject_q <= reject;
      if (strb.dir) dir_q <= wdata;
      if (strb.aux) aux_q <= wdata;
    end
  end

  p_dir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dir |=> dir_q == $past(wdata));

  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.set && (wdata & dir_q) != '0) |=>
      ((level_q & $past(wdata) & $past(dir_q)) == ($past(wdata) & $past(dir_q))));

  p_clr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clr && (wdata & dir_q) != '0) |=>
      ((level_q & $past(wdata) & $past(dir_q)) == '0));

  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb.set || strb.clr) && (wdata & dir_q) == '0) |=>
      ((level_q & $past(dir_q)) == ($past(level_q) & $past(dir_q))));

  p_input_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((level_q ^ $past(pin_i)) & ~$past(dir_q)) == '0));
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] level_q,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0] aux_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (re) begin
      unique case (addr)
        OFF_LEVEL: rdata = level_q;
        OFF_DIR:   rdata = dir_q;
        OFF_AUX:   rdata = aux_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int N_LOW_IRQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] pin_oe,
  output logic [N_LOW_IRQ-1:0] irq_low,
  output logic              irq_high,
  output logic              wr_err
);
  wr_strb_t          strb;
  logic [DATA_W-1:0] level_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] aux_q;

  gpio_decode u_dec (
    .addr (addr),
    .we   (we),
    .strb (strb)
  );

  gpio_state #(.DATA_W(DATA_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wdata    (wdata),
    .pin_i    (pin_i),
    .level_q  (level_q),
    .dir_q    (dir_q),
    .aux_q    (aux_q),
    .reject_q (wr_err)
  );

  gpio_readmux #(.DATA_W(DATA_W)) u_rd (
    .re      (re),
    .addr    (addr),
    .level_q (level_q),
    .dir_q   (dir_q),
    .aux_q   (aux_q),
    .rdata   (rdata)
  );

  assign pin_o  = level_q & dir_q;
  assign pin_oe = dir_q;

  // no edge detection: every interrupt line is tied low (R11)
  for (genvar i = 0; i < N_LOW_IRQ; i++) begin : g_irq_low
    assign irq_low[i] = 1'b0;
  end
  assign irq_high = 1'b0;

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($past(we) && ($past(addr) == OFF_SET || $past(addr) == OFF_CLR)));

  p_oe_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_DIR) |=> pin_oe == $past(wdata));
endmodule

// File: tb/sim_gpio_regblock.sv
`timescale 1ns/1ps
module sim_gpio_regblock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o;
  logic [31:0] pin_oe;
  logic [7:0]  irq_low;
  logic        irq_high;
  logic        wr_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_level = '0, m_dir = '0, m_aux = '0;
  logic        m_err = 1'b0;

  always #10 clk = ~clk;

  gpio_regblock u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .irq_low(irq_low), .irq_high(irq_high), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic r);
    if (!r) return '0;
    case (a)
      8'h00: return m_level;
      8'h04: return m_dir;
      8'h20: return m_aux;
      default: return '0;
    endcase
  endfunction

  // one bus cycle: drive at negedge, check read, clock, check registered outputs
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] p);
    logic [31:0] mod;
    logic        is_sc;
    we = w; re = r; addr = a; wdata = d; pin_i = p;
    #1;
    check((r && (a == 8'h00 || a == 8'h04 || a == 8'h20)) ? "R2 read decode" :
          (r ? "R3 unknown read" : "R12 idle read"), rdata, model_read(a, r));
    is_sc = w && (a == 8'h08 || a == 8'h0C);
    mod = m_level;
    if (is_sc && (d & m_dir) != 0) mod = (a == 8'h08) ? (m_level | d) : (m_level & ~d);
    @(posedge clk);
    m_err   = is_sc && ((d & m_dir) == 0);
    m_level = (mod & m_dir) | (p & ~m_dir);
    if (w && a == 8'h04) m_dir = d;
    if (w && a == 8'h20) m_aux = d;
    @(negedge clk);
    check("R7 error strobe", {31'd0, wr_err}, {31'd0, m_err});
    check("R10 pin_o", pin_o, m_level & m_dir);
    check("R10 pin_oe", pin_oe, m_dir);
    check("R11 irq lines", {23'd0, irq_high, irq_low}, 32'd0);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b1, a, 32'h0, pin_i);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset pin_oe", pin_oe, 32'h0);
    check("R1 reset err", {31'd0, wr_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h04); rd(8'h20); rd(8'h00);
    check("R1 reset dir", m_dir, 32'h0);
    // R4 direction and scratch loads
    step(1'b1, 1'b0, 8'h04, 32'h0000_00FF, 32'h0);
    step(1'b1, 1'b0, 8'h20, 32'hCAFE_F00D, 32'h0);
    rd(8'h04); rd(8'h20);
    // R5 set with overlap, stray bits onto inputs (R9)
    step(1'b1, 1'b0, 8'h08, 32'h0F00_0055, 32'h0);
    rd(8'h00);
    check("R5 set result", m_level & m_dir, 32'h0000_0055);
    // R6 clear with overlap
    step(1'b1, 1'b0, 8'h0C, 32'h0000_0041, 32'h0);
    rd(8'h00);
    // R7 rejected set and clear, back to back
    step(1'b1, 1'b0, 8'h08, 32'hFF00_0000, 32'h1234_5600);
    step(1'b1, 1'b0, 8'h0C, 32'h0000_FF00, 32'h1234_5600);
    step(1'b0, 1'b0, 8'h00, 32'h0, 32'h1234_5600);
    rd(8'h00);
    // R8 edge offsets and undecoded offsets ignored
    step(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF, 32'h0);
    rd(8'h04); rd(8'h20); rd(8'h00);
    // R3 reads of write-only and edge offsets
    rd(8'h08); rd(8'h0C); rd(8'h10); rd(8'h18); rd(8'hFC);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      case ($urandom_range(0, 9))
        0: a = 8'h00; 1: a = 8'h04; 2, 3: a = 8'h08; 4, 5: a = 8'h0C;
        6: a = 8'h10 + 8'($urandom_range(0, 2) * 4); 7: a = 8'h20;
        default: a = 8'($urandom);
      endcase
      d = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      step(1'($urandom), 1'($urandom), a, d, $urandom);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule